// File: doc/BRIEF.md
# Digit-Serial BCD Double Accumulator

This block adds decimal numbers one BCD digit at a time, least significant digit first, with a single one-digit BCD adder whose carry is latched and fed back for the next digit. A frame lasts two five-clock halves, selected by an external sequencer through two enables. In the first half the five incoming digits pass through the adder into a result latch. The latched digits then shift along a delay line that has a head section of four digit stages followed by a tail section of five stages.

In the second half the digit input is gated off. The head section's output, which by then holds the first-half digit of the same weight, drives both adder operands. The second half therefore adds the first-half value to itself, and at the end of the frame the doubled value sits in the result latch and the head section. The first-half value has moved on into the tail section. A separate carry-enable input decides on each clock whether the latched carry reaches the adder. The sequencer uses it to clear the carry at the start of each half. Both parallel words stay frozen while neither enable is high.

Top module: `bcd_double_acc`

## Requirements
- R1: While `rst_n` is low, `result_bcd`, `result_carry` and `first_pass_bcd` are all zero.
- R2: After a frame (five clocks with `pass1_en` high carrying digits d0..d4, least significant first, then five clocks with `pass2_en` high), `first_pass_bcd` holds the input number N. Digit j sits in bits [4j+3:4j].
- R3: After such a frame, with `carry_tick` low on the first clock of each half and high on the others, `result_bcd` holds 2·N mod 100000 in the same digit layout and `result_carry` is 1 exactly when 2·N ≥ 100000.
- R4: Every digit of `result_bcd` is in the range 0 to 9. A per-digit sum above 9 is brought back into range by adding 6, and it produces a carry.
- R5: A carry produced by one digit is added into the next more significant digit of the same half. The carry therefore ripples across runs of 9s.
- R6: The latched carry enters the adder only on clocks where `carry_tick` is high. With it low the carry-in is 0. With it high on the first clock of a frame, the previous frame's final carry is added into digit 0 of the first half.
- R7: While `pass1_en` and `pass2_en` are both low, all outputs hold their values whatever the other inputs do.
- R8: The value on `dig_in` has no effect while `pass2_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dig_in | input | 4 | Incoming BCD digit, least significant first |
| pass1_en | input | 1 | High for the five clocks of the first half |
| pass2_en | input | 1 | High for the five clocks of the second half |
| carry_tick | input | 1 | Lets the latched carry into the adder on this clock |
| result_bcd | output | 20 | Doubled result, five BCD digits, digit 0 in the low nibble |
| result_carry | output | 1 | Carry out of the most significant digit of the last half |
| first_pass_bcd | output | 20 | First-half result held in the tail section, digit 0 in the low nibble |

## Verification
The bench sweeps the input number across the whole five-digit range with a fixed stride and adds the values where decimal correction matters: all 9s, 50000, and single digits of 5. A design that forgot the +6 correction would show hexadecimal digits, and one with a dropped or late carry would fail on 99999 and 55555. Frames with the carry enable held high on the first clock check that a stale final carry leaks in as specified. Frames with it held low through the second half show whether the gating really cuts the ripple. A delay line one stage off would pair the wrong digits and corrupt nearly every doubled result. Idle gaps with a changing `dig_in`, and second halves driven with different junk digits, expose any leak from the gated input.

// File: rtl/bcd_dacc_pkg.sv
package bcd_dacc_pkg;
  typedef logic [3:0] bcd_t;

  typedef struct packed {
    logic carry;
    bcd_t digit;
  } dsum_t;
endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
  import bcd_dacc_pkg::*;
(
  input  bcd_t a,
  input  bcd_t b,
  input  logic cin,
  output dsum_t res
);
  logic [4:0] raw;
  logic [4:0] fixed;

  always_comb begin
    raw   = {1'b0, a} + {1'b0, b} + {4'd0, cin};
    fixed = raw + 5'd6;
    if (raw > 5'd9) begin
      res.digit = fixed[3:0];
      res.carry = 1'b1;
    end else begin
      res.digit = raw[3:0];
      res.carry = 1'b0;
    end
  end
endmodule

// File: rtl/bcd_digit_shifter.sv
module bcd_digit_shifter
  import bcd_dacc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             adv,
  input  bcd_t             din,
  output logic [DEPTH*4-1:0] stages,
  output bcd_t             tap
);
  bcd_t stage_q [DEPTH];
  bcd_t stage_d [DEPTH];

  always_comb begin
    stage_d[0] = adv ? din : stage_q[0];
    for (int k = 1; k < DEPTH; k++) begin
      stage_d[k] = adv ? stage_q[k-1] : stage_q[k];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) stage_q[g] <= '0;
      else         stage_q[g] <= stage_d[g];
    end
    assign stages[g*4 +: 4] = stage_q[g];
  end

  assign tap = stage_q[DEPTH-1];
endmodule

// File: rtl/bcd_double_acc.sv
module bcd_double_acc
  import bcd_dacc_pkg::*;
#(
  parameter int NDIG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        dig_in,
  input  logic              pass1_en,
  input  logic              pass2_en,
  input  logic              carry_tick,
  output logic [NDIG*4-1:0] result_bcd,
  output logic              result_carry,
  output logic [NDIG*4-1:0] first_pass_bcd
);
  localparam int HEAD = NDIG - 1;
  localparam int TAIL = NDIG;

  logic srst_n;
  logic run;
  logic second;
  bcd_t op_a;
  bcd_t op_b;
  logic cin;
  dsum_t add_res;
  dsum_t lat_q;
  dsum_t lat_d;
  bcd_t head_tap;
  bcd_t tail_tap;
  logic [HEAD*4-1:0] head_all;
  logic [TAIL*4-1:0] tail_all;

  bcd_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    run    = pass1_en | pass2_en;
    second = pass2_en & ~pass1_en;
    op_a   = pass1_en ? dig_in : (second ? head_tap : 4'd0);
    op_b   = second ? head_tap : 4'd0;
    cin    = carry_tick & lat_q.carry;
    lat_d  = run ? add_res : lat_q;
  end

  bcd_digit_adder u_add (
    .a   (op_a),
    .b   (op_b),
    .cin (cin),
    .res (add_res)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) lat_q <= '0;
    else         lat_q <= lat_d;
  end

  bcd_digit_shifter #(.DEPTH(HEAD)) u_head (
    .clk    (clk),
    .srst_n (srst_n),
    .adv    (run),
    .din    (lat_q.digit),
    .stages (head_all),
    .tap    (head_tap)
  );

  bcd_digit_shifter #(.DEPTH(TAIL)) u_tail (
    .clk    (clk),
    .srst_n (srst_n),
    .adv    (run),
    .din    (head_tap),
    .stages (tail_all),
    .tap    (tail_tap)
  );

  for (genvar j = 0; j < HEAD; j++) begin : g_res
    assign result_bcd[j*4 +: 4] = head_all[(HEAD-1-j)*4 +: 4];
  end
  assign result_bcd[HEAD*4 +: 4] = lat_q.digit;
  assign result_carry            = lat_q.carry;

  for (genvar j = 0; j < TAIL; j++) begin : g_fp
    assign first_pass_bcd[j*4 +: 4] = tail_all[(TAIL-1-j)*4 +: 4];
  end

  logic unused_tap;
  assign unused_tap = ^tail_tap;
endmodule

// File: rtl/bcd_double_acc_chk.sv
module bcd_double_acc_chk #(
  parameter int NDIG = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        dig_in,
  input logic              pass1_en,
  input logic              pass2_en,
  input logic              carry_tick,
  input logic [NDIG*4-1:0] result_bcd,
  input logic              result_carry,
  input logic [NDIG*4-1:0] first_pass_bcd
);
  function automatic logic all_decimal(input logic [NDIG*4-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NDIG; k++) begin
      if (v[k*4 +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (result_bcd == '0 && !result_carry && first_pass_bcd == '0));

  assert_digits_decimal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    all_decimal(result_bcd));

  assert_gated_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pass1_en && !carry_tick && dig_in <= 4'd9) |=> !result_carry);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass1_en && !pass2_en) |=>
      ($stable(result_bcd) && $stable(result_carry) && $stable(first_pass_bcd)));
endmodule

bind bcd_double_acc bcd_double_acc_chk #(.NDIG(NDIG)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dig_in         (dig_in),
  .pass1_en       (pass1_en),
  .pass2_en       (pass2_en),
  .carry_tick     (carry_tick),
  .result_bcd     (result_bcd),
  .result_carry   (result_carry),
  .first_pass_bcd (first_pass_bcd)
);

// File: tb/tb_bcd_double_acc.sv
module tb_bcd_double_acc;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [3:0]  dig_in;
  logic        pass1_en;
  logic        pass2_en;
  logic        carry_tick;
  logic [19:0] result_bcd;
  logic        result_carry;
  logic [19:0] first_pass_bcd;

  int n_checks;
  int n_fails;

  bcd_double_acc dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .dig_in         (dig_in),
    .pass1_en       (pass1_en),
    .pass2_en       (pass2_en),
    .carry_tick     (carry_tick),
    .result_bcd     (result_bcd),
    .result_carry   (result_carry),
    .first_pass_bcd (first_pass_bcd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int digit_of(input int n, input int i);
    int v;
    v = n;
    for (int k = 0; k < i; k++) v = v / 10;
    return v % 10;
  endfunction

  function automatic logic [19:0] to_bcd(input int n);
    logic [19:0] r;
    for (int i = 0; i < 5; i++) r[i*4 +: 4] = 4'(digit_of(n, i));
    return r;
  endfunction

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ctl_p1: carry_tick on first clock of first half; ctl_p2: on first clock of
  // second half; rest_p2: on remaining second-half clocks; junk: dig_in in half two
  task automatic run_frame(input int n, input logic ctl_p1, input logic ctl_p2,
                           input logic rest_p2, input int junk);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      pass1_en   = (c < 5);
      pass2_en   = (c >= 5);
      dig_in     = (c < 5) ? 4'(digit_of(n, c)) : 4'((junk + c) % 10);
      if (c == 0)      carry_tick = ctl_p1;
      else if (c == 5) carry_tick = ctl_p2;
      else if (c > 5)  carry_tick = rest_p2;
      else             carry_tick = 1'b1;
    end
    @(negedge clk);
    pass1_en   = 1'b0;
    pass2_en   = 1'b0;
    carry_tick = 1'b0;
  endtask

  task automatic std_frame(input int n, input int junk);
    int dbl;
    run_frame(n, 1'b0, 1'b0, 1'b1, junk);
    dbl = 2 * n;
    check("R2 first pass", {1'b0, first_pass_bcd}, {1'b0, to_bcd(n)});
    check("R3 doubled", {result_carry, result_bcd},
          {(dbl >= 100000), to_bcd(dbl % 100000)});
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    rst_n = 1'b1;
    dig_in = '0; pass1_en = 1'b0; pass2_en = 1'b0; carry_tick = 1'b0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", {result_carry, result_bcd}, 21'd0);
    check("R1 reset first", {1'b0, first_pass_bcd}, 21'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4/R5 corner values
    std_frame(99999, 3);
    std_frame(55555, 0);
    std_frame(5, 7);
    std_frame(49999, 1);
    std_frame(0, 2);

    // R6: stale final carry admitted on first clock
    std_frame(50000, 4);
    run_frame(12345, 1'b1, 1'b0, 1'b1, 5);
    check("R6 carry leak first", {1'b0, first_pass_bcd}, {1'b0, to_bcd(12346)});
    check("R6 carry leak result", {result_carry, result_bcd}, {1'b0, to_bcd(24692)});

    // R6: gate held low through second half cuts the ripple
    run_frame(56789, 1'b0, 1'b0, 1'b0, 6);
    begin
      logic [19:0] e;
      for (int i = 0; i < 5; i++) e[i*4 +: 4] = 4'((2 * digit_of(56789, i)) % 10);
      check("R6 no ripple", {result_carry, result_bcd}, {1'b1, e});
    end

    // R7: idle hold with moving input
    std_frame(31415, 8);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      dig_in = 4'(k * 3);
      carry_tick = k[0];
    end
    @(negedge clk);
    check("R7 idle result", {result_carry, result_bcd}, {1'b0, to_bcd(62830)});
    check("R7 idle first", {1'b0, first_pass_bcd}, {1'b0, to_bcd(31415)});

    // R8: different junk in second half gives same answer
    run_frame(77777, 1'b0, 1'b0, 1'b1, 0);
    check("R8 junk a", {result_carry, result_bcd}, {1'b1, to_bcd(55554)});
    run_frame(77777, 1'b0, 1'b0, 1'b1, 9);
    check("R8 junk b", {result_carry, result_bcd}, {1'b1, to_bcd(55554)});

    // R2/R3/R4/R5 sweep over the number range
    for (int n = 0; n < 100000; n += 47) std_frame(n, n % 10);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule